// File: doc/BRIEF.md
# LCD Panel Reset Sequencer

This block produces the hardware reset waveform for an external display panel. On a start pulse it holds the panel reset line at the released level, then pulls it to the asserted level, then releases it again. Each of the three intervals has its own programmed length. The first two lengths count in 10 µs units and the third in 100 µs units. Both unit sizes come from a prescaler that counts reference-clock cycles.

An optional settle interval can follow the third phase. It also counts in 100 µs units and holds back the done indication, so that a command engine does not address the panel too early. A polarity input inverts the physical pin for panels whose reset sense is reversed. The lengths are captured when the start pulse is accepted. A single-cycle done pulse marks the end of the sequence.

Top module: `lcd_rst_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, the pin sits at the released level (logical high) and `done` is low.
- R2: The first phase holds the logical pin high for `hi1_len` × 10 × REF_MHZ clock cycles, counted from the edge that accepts `start`.
- R3: The middle phase then drives the logical pin low for `lo_len` × 10 × REF_MHZ cycles. The pin is low at no other time.
- R4: The third phase holds the logical pin high for `hi2_len` × 100 × REF_MHZ cycles.
- R5: When `hold_en` is 1, a settle phase of `hold_len` × 100 × REF_MHZ cycles, with the pin high, follows the third phase. When `hold_en` is 0, `hold_len` has no effect.
- R6: A phase whose length is zero is skipped and takes no cycles. The phases always run in the order first, middle, third, settle.
- R7: `done` is high for exactly one cycle. That cycle is the T-th cycle after the accepting edge, where T is the sum of all phase cycle counts. The block is then idle again. With every length zero, `done` follows the accepting edge directly.
- R8: A `start` pulse that arrives while a sequence is running is ignored.
- R9: All lengths and `hold_en` are captured when `start` is accepted. Changes to them during a sequence have no effect on it.
- R10: `rst_pin` equals the logical pin level XOR `inv_pol`, so `inv_pol` = 1 inverts the physical pin at all times, including idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, REF_MHZ MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a sequence when idle |
| hi1_len | input | LEN_W | First high phase length, 10 µs units |
| lo_len | input | LEN_W | Low phase length, 10 µs units |
| hi2_len | input | LEN_W | Second high phase length, 100 µs units |
| hold_en | input | 1 | Enables the settle phase |
| hold_len | input | LEN_W | Settle phase length, 100 µs units |
| inv_pol | input | 1 | Inverts the physical reset pin |
| rst_pin | output | 1 | Panel reset pin |
| done | output | 1 | One-cycle pulse at sequence end |

## Verification
Every internal error reaches the ports through either the time at which the pin falls, the width of the low window, or the cycle in which `done` appears. A prescaler off by one count moves the `done` pulse by as many cycles as the sequence has units. A wrong phase order or a zero-length phase that is not skipped shifts the low window or the end time by at least one full unit. Any of these faults is therefore visible within one unit of its cause, or at the latest at the `done` pulse of the same run.

// File: rtl/lcd_rst_seq.sv
module lcd_rst_seq #(
  parameter int REF_MHZ = 200,
  parameter int LEN_W   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] hi1_len,
  input  logic [LEN_W-1:0] lo_len,
  input  logic [LEN_W-1:0] hi2_len,
  input  logic             hold_en,
  input  logic [LEN_W-1:0] hold_len,
  input  logic             inv_pol,
  output logic             rst_pin,
  output logic             done
);
  localparam int FINE   = 10 * REF_MHZ;
  localparam int COARSE = 100 * REF_MHZ;
  localparam int PW     = $clog2(COARSE);

  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_H1   = 3'd1;
  localparam logic [2:0] S_LO   = 3'd2;
  localparam logic [2:0] S_H2   = 3'd3;
  localparam logic [2:0] S_HOLD = 3'd4;
  localparam logic [2:0] S_DONE = 3'd5;

  logic [2:0]             st, nxt;
  logic [PW-1:0]          pre;
  logic [LEN_W-1:0]       ucnt, cur_len;
  logic [3:0][LEN_W-1:0]  lat, eff;
  logic                   fine_ph, unit_end, last;

  assign eff = (st == S_IDLE)
             ? {(hold_en ? hold_len : {LEN_W{1'b0}}), hi2_len, lo_len, hi1_len}
             : lat;

  always_comb begin
    nxt = S_DONE;
    for (int j = 4; j >= 1; j--)
      if (j > int'(st) && eff[j-1] != {LEN_W{1'b0}}) nxt = 3'(j);
  end

  always_comb begin
    case (st)
      S_H1:    cur_len = eff[0];
      S_LO:    cur_len = eff[1];
      S_H2:    cur_len = eff[2];
      S_HOLD:  cur_len = eff[3];
      default: cur_len = '0;
    endcase
  end

  assign fine_ph  = (st == S_H1) || (st == S_LO);
  assign unit_end = fine_ph ? (pre == PW'(FINE - 1)) : (pre == PW'(COARSE - 1));
  assign last     = unit_end && (ucnt == cur_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      pre  <= '0;
      ucnt <= '0;
      lat  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          lat  <= eff;
          st   <= nxt;
          pre  <= '0;
          ucnt <= '0;
        end
        S_DONE: st <= S_IDLE;
        default: begin
          if (unit_end) begin
            pre <= '0;
            if (last) begin
              st   <= nxt;
              ucnt <= '0;
            end else begin
              ucnt <= ucnt + 1'b1;
            end
          end else begin
            pre <= pre + 1'b1;
          end
        end
      endcase
    end
  end

  assign rst_pin = (st != S_LO) ^ inv_pol;
  assign done    = (st == S_DONE);
endmodule

// File: rtl/lcd_rst_seq_chk.sv
module lcd_rst_seq_chk #(
  parameter int LEN_W  = 11,
  parameter int PW     = 15,
  parameter int COARSE = 20000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               inv_pol,
  input logic               rst_pin,
  input logic               done,
  input logic [2:0]         st,
  input logic [PW-1:0]      pre,
  input logic [4*LEN_W-1:0] lat
);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (st == 3'd0));

  p_idle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> (rst_pin == ~inv_pol));

  p_released_at_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rst_pin ^ inv_pol));

  p_len_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 3'd0) |=> $stable(lat));

  p_phase_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 3'd0 && st != 3'd5) |=> (st >= $past(st)));

  p_prescale_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pre) < COARSE);
endmodule

bind lcd_rst_seq lcd_rst_seq_chk #(.LEN_W(LEN_W), .PW(PW), .COARSE(COARSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .inv_pol(inv_pol), .rst_pin(rst_pin), .done(done),
  .st(st), .pre(pre), .lat(lat)
);

// File: tb/tb_lcd_rst_seq.sv
`timescale 1ns/1ps
module tb_lcd_rst_seq;
  localparam int LEN_W = 11;
  localparam int NV    = 7;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, hold_en = 1'b0, inv_pol = 1'b0;
  logic [LEN_W-1:0] hi1_len = '0, lo_len = '0, hi2_len = '0, hold_len = '0;
  logic rst_pin, done;
  int errors = 0, checks = 0, cyc = 0;

  always #2.5 clk = ~clk;

  lcd_rst_seq #(.REF_MHZ(1), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .hi1_len(hi1_len), .lo_len(lo_len),
    .hi2_len(hi2_len), .hold_en(hold_en), .hold_len(hold_len), .inv_pol(inv_pol),
    .rst_pin(rst_pin), .done(done)
  );

  // h1, lo, h2, hold_en, hold, pol, exp_done_at, exp_first_low, exp_low_cnt
  localparam int VEC [NV][9] = '{
    '{2, 3, 1, 0, 0, 0, 150,  20, 30},
    '{1, 1, 1, 1, 2, 0, 320,  10, 10},
    '{0, 2, 1, 0, 5, 1, 120,   0, 20},
    '{3, 0, 0, 0, 0, 0,  30,  -1,  0},
    '{0, 0, 0, 0, 0, 1,   0,  -1,  0},
    '{1, 2, 0, 1, 1, 1, 130,  10, 20},
    '{0, 0, 2, 1, 0, 0, 200,  -1,  0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0: none, 1: extra start at dist_k, 2: change lengths at dist_k
  task automatic run(input int h1, input int lo, input int h2, input int en, input int hd,
                     input int pol, input int mode, input int dist_k,
                     output int done_at, output int first_low, output int low_cnt,
                     output int done_cnt, output bit idle_ok);
    done_at = -1; first_low = -1; low_cnt = 0; done_cnt = 0; idle_ok = 1'b0;
    @(negedge clk);
    hi1_len = LEN_W'(h1); lo_len = LEN_W'(lo); hi2_len = LEN_W'(h2);
    hold_en = en[0]; hold_len = LEN_W'(hd); inv_pol = pol[0];
    start = 1'b1;
    @(posedge clk);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (mode == 1 && k == dist_k) start = 1'b1;
      if (mode == 2 && k == dist_k) begin
        hi1_len = 11'd9; lo_len = 11'd9; hi2_len = 11'd7; hold_en = 1'b1; hold_len = 11'd4;
      end
      if (!(rst_pin ^ inv_pol)) begin
        if (first_low < 0) first_low = k;
        low_cnt++;
      end
      if (done) begin
        done_cnt++;
        if (done_at < 0) done_at = k;
      end
      if (done_at >= 0 && k == done_at + 1) begin
        idle_ok = !done && (rst_pin == ~inv_pol);
        break;
      end
    end
    start = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int da, fl, lc, dc;
    bit io;
    inv_pol = 1'b0;
    #1;
    check(rst_pin == 1'b1 && done == 1'b0, "R1 reset level", rst_pin, 1);
    inv_pol = 1'b1;
    #1;
    check(rst_pin == 1'b0, "R10 inverted idle", rst_pin, 0);
    inv_pol = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rst_pin == 1'b1 && done == 1'b0, "R1 idle after reset", rst_pin, 1);

    for (int v = 0; v < NV; v++) begin
      run(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], 0, 0,
          da, fl, lc, dc, io);
      check(da == VEC[v][6], "R7 R4 R5 done time", da, VEC[v][6]);
      check(fl == VEC[v][7], "R2 R6 low start", fl, VEC[v][7]);
      check(lc == VEC[v][8], "R3 low width", lc, VEC[v][8]);
      check(dc == 1 && io, "R7 R10 single done then idle", dc, 1);
      repeat (2) @(negedge clk);
    end

    run(2, 3, 1, 0, 0, 0, 1, 50, da, fl, lc, dc, io);
    check(da == 150, "R8 extra start ignored", da, 150);
    repeat (300) @(negedge clk);
    check(rst_pin == 1'b1 && done == 1'b0, "R8 no restart afterwards", done, 0);

    run(2, 3, 1, 0, 0, 0, 2, 5, da, fl, lc, dc, io);
    check(da == 150 && lc == 30, "R9 lengths captured", da, 150);
    @(negedge clk);
    hold_en = 1'b0; hold_len = 11'd3;

    run(1, 1, 1, 0, 9, 1, 0, 0, da, fl, lc, dc, io);
    check(da == 120, "R5 hold_len ignored when disabled", da, 120);
    check(fl == 10 && lc == 10, "R10 R3 inverted low window", fl, 10);

    run(0, 4, 0, 0, 0, 0, 0, 0, da, fl, lc, dc, io);
    check(fl == 0 && lc == 40 && da == 40, "R6 only low phase", da, 40);

    @(negedge clk);
    hi1_len = 11'd1; lo_len = 11'd5; hi2_len = 11'd1; hold_en = 1'b0; inv_pol = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (15) @(negedge clk);
    check(rst_pin == 1'b0, "R3 low mid-sequence", rst_pin, 0);
    rst_n = 1'b0;
    #1;
    check(rst_pin == 1'b1 && done == 1'b0, "R1 reset mid-sequence", rst_pin, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    check(rst_pin == 1'b1 && done == 1'b0, "R1 stays idle after reset", done, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule